// File: doc/BRIEF.md
# Serial Phase-Word Programming Master

This block sits on the host side of a three-wire serial link to one or more digital phase-shifter units that share a data line and are told apart by a 4-bit unit address. A client supplies an 8-bit phase state, a unit address and a one-cycle start pulse. The block then builds a 13-bit program word and clocks it out. The serial clock rate comes from a run-time divider. At the end of the word the block raises the latch line to commit it. The phase state is the wanted angle scaled by 256/360, so 205.3 degrees is state 146. That conversion is done by the client.

The word goes out least significant bit first. The eight phase bits come first, then an accuracy-trim bit, then the four address bits. The trim bit is not an input: the block copies it from phase bit 6, the 90-degree bit. When readback is requested, the block samples the chained serial output of the last unit on each falling serial-clock edge. It returns the 13 captured bits together with a one-cycle valid strobe.

The controller stays busy until the latch pulse has ended and a programmable quiet interval has run out. This lets the host keep updates slow enough for units in their slow bias mode, which accept at most 25 000 updates per second. Start pulses that arrive while the block is busy are dropped.

Top module: `phase_prog_master`

## Requirements
- R1: After reset, and whenever busy is low, sclk, sle, sdata, busy and rb_valid are all low, and rb_word is zero after reset.
- R2: One transfer sends exactly 13 bits, sampled by the unit on rising sclk edges, in this order: phase_state[0..7], then the trim bit, then unit_addr[0..3]. For example, state 146 at address 3 sends 0,1,0,0,1,0,0,1,0,1,1,0,0.
- R3: The ninth bit sent (the trim bit) always equals phase_state[6].
- R4: sdata changes only while sclk is low. It holds its value for the whole high phase of every sclk pulse.
- R5: While shifting, sclk has a period of 2*(half_div+1) system cycles, with a high phase of exactly half_div+1 cycles.
- R6: sle stays low while the 13 bits are clocked. It rises together with the 13th falling sclk edge and stays high for 2*(half_div+1) cycles, with sclk low for that whole time. It rises only once per transfer.
- R7: With readback_en high at start, sdo_in is sampled at each falling sclk edge. The sample taken after rising edge k lands in rb_word[k], and rb_valid pulses for one cycle in the cycle that sle rises. With readback_en low, rb_valid stays low and rb_word keeps its value.
- R8: Busy is high in the cycle after an accepted start pulse.
- R9: After sle falls, busy stays high for exactly min_gap+1 system cycles.
- R10: A start pulse while busy is ignored. The word in flight is unchanged and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe |
| unit_addr | input | 4 | Address of the unit to program |
| phase_state | input | 8 | Phase state, angle times 256/360 |
| readback_en | input | 1 | Capture returned bits during this transfer |
| half_div | input | DIV_W | sclk half period minus one, in system cycles |
| min_gap | input | GAP_W | Quiet interval after the latch pulse, minus one |
| sdo_in | input | 1 | Chained serial output from the last unit |
| sclk | output | 1 | Serial clock |
| sdata | output | 1 | Serial data |
| sle | output | 1 | Latch enable |
| busy | output | 1 | Transfer or quiet interval in progress |
| rb_valid | output | 1 | One-cycle strobe: rb_word holds fresh readback |
| rb_word | output | 13 | Captured readback bits |

## Verification
The hardest case to reach is a start request that lands in the middle of a transfer. To get there, the stimulus counts rising sclk edges and injects a second start, carrying different phase and address values, right after a chosen edge. It then checks that the bits on the wire still match the first request and that no latch pulse follows. Readback timing is also hard to check. Here the bench acts as a chained unit: it changes sdo_in only just after each rising sclk edge, so a capture taken on the wrong edge would give a different word.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int unsigned PH_W   = 8;
  localparam int unsigned AD_W   = 4;
  localparam int unsigned TRIM_SRC = PH_W - 2;          // 90-degree bit
  localparam int unsigned WORD_W = PH_W + 1 + AD_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LATCH = 2'd2,
    ST_QUIET = 2'd3
  } xfer_state_t;

  // Program word as it leaves the shifter, bit 0 first on the wire.
  function automatic logic [WORD_W-1:0] build_word(input logic [PH_W-1:0] ph,
                                                   input logic [AD_W-1:0] ad);
    return {ad, ph[TRIM_SRC], ph};
  endfunction
endpackage

// File: rtl/pps_tick.sv
module pps_tick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == half_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  // R5: the half-period counter never passes its limit
  assert_tick_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run && $stable(half_div) |-> cnt <= half_div);
endmodule

// File: rtl/pps_gap.sv
module pps_gap #(
  parameter int unsigned GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [GAP_W-1:0] limit,
  output logic             done
);
  logic [GAP_W-1:0] cnt;

  assign done = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || done) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  // R9: the quiet interval ends exactly at its limit
  assert_gap_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run && $stable(limit) |-> cnt <= limit);
endmodule

// File: rtl/pps_xfer.sv
module pps_xfer
  import pps_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AD_W-1:0]   unit_addr,
  input  logic [PH_W-1:0]   phase_state,
  input  logic              readback_en,
  input  logic              tick,
  input  logic              gap_done,
  input  logic              sdo_in,
  output logic              tick_run,
  output logic              gap_run,
  output logic              sclk,
  output logic              sdata,
  output logic              sle,
  output logic              busy,
  output logic              rb_valid,
  output logic [WORD_W-1:0] rb_word
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] BIT_D6   = CNT_W'(TRIM_SRC);
  localparam logic [CNT_W-1:0] BIT_TRIM = CNT_W'(PH_W);

  xfer_state_t       st;
  logic [WORD_W-1:0] sh;
  logic [WORD_W-1:0] rb_sh;
  logic [WORD_W-1:0] new_word;
  logic [CNT_W-1:0]  bitn;
  logic              sclk_q, sd_q, rb_on, rb_v, le_half, d6_q;

  // named internal events
  logic accept_ev, rise_ev, fall_ev, last_bit;
  assign new_word  = build_word(phase_state, unit_addr);
  assign accept_ev = (st == ST_IDLE) && start;
  assign rise_ev   = (st == ST_SHIFT) && tick && !sclk_q;
  assign fall_ev   = (st == ST_SHIFT) && tick && sclk_q;
  assign last_bit  = (bitn == BIT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      sh      <= '0;
      rb_sh   <= '0;
      bitn    <= '0;
      sclk_q  <= 1'b0;
      sd_q    <= 1'b0;
      rb_on   <= 1'b0;
      rb_v    <= 1'b0;
      le_half <= 1'b0;
    end else begin
      rb_v <= 1'b0;
      unique case (st)
        ST_IDLE: if (accept_ev) begin
          sh      <= new_word;
          sd_q    <= new_word[0];
          bitn    <= '0;
          rb_on   <= readback_en;
          le_half <= 1'b0;
          st      <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (rise_ev) sclk_q <= 1'b1;
          if (fall_ev) begin
            sclk_q <= 1'b0;
            if (rb_on) rb_sh <= {sdo_in, rb_sh[WORD_W-1:1]};
            sh   <= sh >> 1;
            bitn <= bitn + 1'b1;
            if (last_bit) begin
              sd_q <= 1'b0;
              rb_v <= rb_on;
              st   <= ST_LATCH;
            end else begin
              sd_q <= sh[1];
            end
          end
        end
        ST_LATCH: if (tick) begin
          if (le_half) st <= ST_QUIET;
          else         le_half <= 1'b1;
        end
        ST_QUIET: if (gap_done) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // trim-bit reference, taken from the wire at the 90-degree bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       d6_q <= 1'b0;
    else if (rise_ev && bitn == BIT_D6) d6_q <= sd_q;
  end

  assign tick_run = (st == ST_SHIFT) || (st == ST_LATCH);
  assign gap_run  = (st == ST_QUIET);
  assign sclk     = sclk_q;
  assign sdata    = sd_q;
  assign sle      = (st == ST_LATCH);
  assign busy     = (st != ST_IDLE);
  assign rb_valid = rb_v;
  assign rb_word  = rb_sh;

  // R1: idle lines are quiet
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk && !sle && !rb_valid);
  // R3: the trim bit on the wire repeats the 90-degree bit
  assert_trim_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev && bitn == BIT_TRIM |-> sd_q == d6_q);
  // R4: data is held across the high phase of sclk
  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk && $past(sclk) |-> $stable(sdata));
  // R6: clock is parked low while the latch is open
  assert_le_clk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sle |-> !sclk);
  // R7: readback strobe is a single cycle and lines up with the latch
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid |-> sle ##1 !rb_valid);
  // R10: a start while busy does not restart the bit count
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !fall_ev |=> $stable(bitn));
endmodule

// File: rtl/phase_prog_master.sv
module phase_prog_master
  import pps_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned GAP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AD_W-1:0]   unit_addr,
  input  logic [PH_W-1:0]   phase_state,
  input  logic              readback_en,
  input  logic [DIV_W-1:0]  half_div,
  input  logic [GAP_W-1:0]  min_gap,
  input  logic              sdo_in,
  output logic              sclk,
  output logic              sdata,
  output logic              sle,
  output logic              busy,
  output logic              rb_valid,
  output logic [WORD_W-1:0] rb_word
);
  logic tick, tick_run, gap_run, gap_done;

  pps_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(tick_run), .half_div(half_div), .tick(tick)
  );

  pps_gap #(.GAP_W(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .run(gap_run), .limit(min_gap), .done(gap_done)
  );

  pps_xfer u_xfer (
    .clk(clk), .rst_n(rst_n), .start(start), .unit_addr(unit_addr),
    .phase_state(phase_state), .readback_en(readback_en), .tick(tick),
    .gap_done(gap_done), .sdo_in(sdo_in), .tick_run(tick_run), .gap_run(gap_run),
    .sclk(sclk), .sdata(sdata), .sle(sle), .busy(busy), .rb_valid(rb_valid),
    .rb_word(rb_word)
  );

  // R8: busy follows an idle-time start by one cycle
  assert_busy_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy);
endmodule

// File: tb/sim_phase_prog_master.sv
module sim_phase_prog_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  unit_addr = '0;
  logic [7:0]  phase_state = '0;
  logic        readback_en = 1'b0;
  logic [7:0]  half_div = '0;
  logic [15:0] min_gap = '0;
  logic        sdo_in = 1'b0;
  logic        sclk, sdata, sle, busy, rb_valid;
  logic [12:0] rb_word;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  phase_prog_master u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .unit_addr(unit_addr),
    .phase_state(phase_state), .readback_en(readback_en), .half_div(half_div),
    .min_gap(min_gap), .sdo_in(sdo_in), .sclk(sclk), .sdata(sdata), .sle(sle),
    .busy(busy), .rb_valid(rb_valid), .rb_word(rb_word)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected wire order: 8 phase bits, copy of phase bit 6, 4 address bits.
  function automatic logic [12:0] expect_bits(input logic [7:0] ph, input logic [3:0] ad);
    logic [12:0] r;
    for (int i = 0; i < 13; i++) begin
      if (i < 8)       r[i] = ph[i];
      else if (i == 8) r[i] = ph[6];
      else             r[i] = ad[i-9];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      chk("WD", "watchdog expired", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "sclk in reset", sclk, 0);
    chk("R1", "sle in reset", sle, 0);
    chk("R1", "sdata in reset", sdata, 0);
    chk("R1", "busy in reset", busy, 0);
    chk("R1", "rb_valid in reset", rb_valid, 0);
    chk("R1", "rb_word in reset", rb_word, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "sclk idle after reset", sclk, 0);
  endtask

  // One full transfer with the bench acting as the chained unit.
  // poke: rising-edge count after which a stray start is injected (0 = none)
  task automatic t_xfer(input logic [7:0] ph, input logic [3:0] ad, input bit rb,
                        input logic [12:0] pat, input int d, input int g, input int poke);
    logic [12:0] got = '0;
    logic [12:0] rb_before;
    int rises = 0, rise_at = -1, le_rise = -1, le_fall = -1, busy_low = -1;
    int vcount = 0, valid_at = -1;
    bit prev_sclk = 0, prev_sle = 0, prev_sd = 0, clear_start = 0;
    bit per_bad = 0, hi_bad = 0, hold_bad = 0, le_clk_bad = 0, le_early = 0;
    half_div = 8'(d); min_gap = 16'(g);
    phase_state = ph; unit_addr = ad; readback_en = rb; sdo_in = 1'b0;
    rb_before = rb_word;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R8", "busy after start", busy, 1);
    for (int n = 0; n < 20000; n++) begin
      if (clear_start) begin
        start = 1'b0; clear_start = 0;
        phase_state = ph; unit_addr = ad;
      end
      if (sclk && !prev_sclk) begin
        if (rises < 13) got[rises] = sdata;
        if (rise_at >= 0 && (n - rise_at) != 2 * (d + 1)) per_bad = 1;
        rise_at = n;
        if (rises < 13) sdo_in = pat[rises];
        rises++;
        if (poke != 0 && rises == poke) begin
          start = 1'b1; phase_state = ~ph; unit_addr = ~ad; clear_start = 1;
        end
      end
      if (!sclk && prev_sclk && (n - rise_at) != d + 1) hi_bad = 1;
      if (sclk && prev_sclk && sdata != prev_sd) hold_bad = 1;
      if (sle && !prev_sle) begin
        if (le_rise >= 0 || rises != 13) le_early = 1;
        le_rise = n;
      end
      if (!sle && prev_sle) le_fall = n;
      if (sle && sclk) le_clk_bad = 1;
      if (rb_valid) begin vcount++; valid_at = n; end
      if (!busy && le_fall >= 0) begin busy_low = n; break; end
      prev_sclk = sclk; prev_sle = sle; prev_sd = sdata;
      @(negedge clk);
    end
    chk("R2", "bit count", rises, 13);
    chk("R2", "sent word", got, expect_bits(ph, ad));
    chk("R3", "trim bit", got[8], ph[6]);
    chk("R4", "data moved while sclk high", hold_bad, 0);
    chk("R5", "sclk period error", per_bad, 0);
    chk("R5", "sclk high-time error", hi_bad, 0);
    chk("R6", "latch high cycles", le_fall - le_rise, 2 * (d + 1));
    chk("R6", "latch timing or repeat", le_early, 0);
    chk("R6", "sclk high during latch", le_clk_bad, 0);
    chk("R9", "busy tail after latch", busy_low - le_fall, g + 1);
    if (rb) begin
      chk("R7", "valid pulses", vcount, 1);
      chk("R7", "valid with latch rise", valid_at, le_rise);
      chk("R7", "readback word", rb_word, pat);
    end else begin
      chk("R7", "valid pulses without readback", vcount, 0);
      chk("R7", "rb_word kept", rb_word, rb_before);
    end
    if (poke != 0) begin
      int extra = 0;
      for (int n = 0; n < 4 * (d + 1) + 8; n++) begin
        @(negedge clk);
        if (sle || busy || sclk) extra = 1;
      end
      chk("R10", "activity after ignored start", extra, 0);
      chk("R10", "word unchanged by stray start", got, expect_bits(ph, ad));
    end
    chk("R1", "busy idle after transfer", busy, 0);
  endtask

  initial begin
    t_reset();
    // 205.3 deg -> state 146 at unit 3
    t_xfer(8'd146, 4'd3, 1'b0, 13'h0, 1, 5, 0);
    chk("R2", "example literal", expect_bits(8'd146, 4'd3), 13'b0011010010010);
    t_xfer(8'h40, 4'hA, 1'b0, 13'h0, 0, 0, 0);   // 90-degree bit only
    t_xfer(8'hBF, 4'h5, 1'b0, 13'h0, 0, 2, 0);   // all but 90-degree bit
    t_xfer(8'hFF, 4'hF, 1'b1, 13'h1A5B, 2, 3, 0);
    t_xfer(8'h00, 4'h0, 1'b1, 13'h0E61, 3, 1, 0);
    t_xfer(8'h5A, 4'h9, 1'b0, 13'h1FFF, 1, 4, 0); // readback off: word kept
    t_xfer(8'h37, 4'h6, 1'b0, 13'h0, 2, 6, 5);    // stray start mid-word
    t_xfer(8'hC3, 4'h2, 1'b0, 13'h0, 0, 1999, 0); // 25 kHz spacing at 50 MHz
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule